// File: doc/BRIEF.md
# Multi-cycle integer divider with condition flags

This block divides a 32-bit dividend by a 32-bit divisor for a processor datapath. It treats both operands as unsigned or as two's complement, as the caller selects, and returns a quotient, a remainder and a four-bit condition-flag vector. A word-mode select changes only the overflow rule: the quotient is then expected to fit in 16 bits. The quotient is written back where the dividend came from and the remainder where the divisor came from. Register writeback is left to the surrounding datapath.

Operands enter on a valid/ready handshake. `in_ready` is high only while the divider is idle. A request is taken on the clock edge where `in_valid` and `in_ready` are both high. While an operation runs, `in_ready` stays low and anything presented on the input side has no effect. The result side has no back-pressure: `out_valid` is a single-cycle strobe, and the consumer must take the result in that cycle. The result registers keep their values until the next successful division, so a late reader still sees them.

A zero divisor does not start a division. The block instead pulses `div_zero` for one cycle and leaves every result output untouched. Exception vectoring is handled outside.

Top module: `div_flags_unit`

## Requirements
- R1: A request is accepted only on a rising clock edge with `in_valid` and `in_ready` both high. `in_ready` is low from the edge after an accepted nonzero-divisor request until the completion cycle, and `in_valid` has no effect while `in_ready` is low.
- R2: For a nonzero divisor, `out_valid` is high for exactly one cycle, 33 clock edges after the accepting edge. `in_ready` is high again in that same cycle.
- R3: In unsigned mode, `quotient` is the floor of dividend/divisor and `remainder` is dividend minus quotient times divisor.
- R4: In signed mode, the quotient is truncated toward zero and the remainder has the sign of the dividend.
- R5: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0. It completes normally with no exception.
- R6: A zero divisor makes `div_zero` high for one cycle, starting one edge after acceptance. `out_valid` stays low, and `quotient`, `remainder` and `flags` keep their earlier values.
- R7: `flags` is laid out as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. On every completion, C is 0. Z is 1 exactly when the 32-bit quotient is zero. N is 1 exactly when the quotient is nonzero and its bit 31 is 1.
- R8: In unsigned word mode, V is 1 exactly when the quotient is greater than 0xFFFF.
- R9: In signed word mode, V is 1 exactly when the quotient differs from the sign extension of its low 16 bits.
- R10: In full 32-bit mode, V is always 0.
- R11: `quotient`, `remainder` and `flags` change only in a completion cycle, and they hold between completions.
- R12: During reset, `quotient`, `remainder`, `flags`, `out_valid` and `div_zero` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request presents operands |
| in_ready | output | 1 | Divider idle and able to take a request |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| word_mode | input | 1 | 1: overflow judged against a 16-bit quotient |
| out_valid | output | 1 | One-cycle strobe marking fresh results |
| quotient | output | 32 | Quotient (goes back to the dividend slot) |
| remainder | output | 32 | Remainder (goes back to the divisor slot) |
| flags | output | 4 | {N, Z, V, C} |
| div_zero | output | 1 | One-cycle divide-by-zero exception strobe |

## Verification
The embedded properties check several rules on every cycle:
- the completion strobe lasts a single cycle;
- a blocked request never produces a divide-by-zero strobe;
- outputs are frozen across an exception and between completions;
- C is always clear, and Z and N are never set together;
- V is never set in full mode;
- an unsigned word-mode quotient without V fits 16 bits;
- the partial remainder inside the iteration stays below the divisor.

Only the bench scenarios can show the arithmetic values themselves: signed truncation and remainder sign, the most-negative-by-minus-one case, the signed word-mode overflow boundaries around ±32768, and the exact 33-edge latency against a reference model that runs alongside the design.

// File: rtl/divf_pkg.sv
package divf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // Flag vector; field order fixes bit positions {N,Z,V,C}
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_flags_t;

  localparam int FLAG_W = $bits(div_flags_t);

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic         sgn_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o
);
  logic num_neg, den_neg;

  always_comb begin
    num_neg   = sgn_i & num_i[W-1];
    den_neg   = sgn_i & den_i[W-1];
    num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
    den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
    neg_quo_o = num_neg ^ den_neg;
    neg_rem_o = num_neg;
  end
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] shq_q;
  logic [W-1:0] den_q;
  logic [W:0]   partial;
  logic [W:0]   trial;
  logic         qbit;
  logic [W-1:0] acc_nxt;

  always_comb begin
    partial = {acc_q, shq_q[W-1]};
    trial   = partial - {1'b0, den_q};
    qbit    = ~trial[W];
    acc_nxt = qbit ? trial[W-1:0] : partial[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      shq_q <= '0;
      den_q <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      shq_q <= num_i;
      den_q <= den_i;
    end else if (step_i) begin
      acc_q <= acc_nxt;
      shq_q <= {shq_q[W-2:0], qbit};
    end
  end

  assign quo_o = shq_q;
  assign rem_o = acc_q;

  AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (den_q != '0) |-> (acc_q < den_q)); // R3
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import divf_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0] uquo_i,
  input  logic [W-1:0] urem_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  input  logic         sgn_i,
  input  logic         word_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output div_flags_t   flags_o
);
  localparam int EXT = W - HW;

  logic [W-1:0] q;
  logic [W-1:0] q_sext;
  logic         ovf_u, ovf_s;

  always_comb begin
    q      = neg_quo_i ? (~uquo_i + 1'b1) : uquo_i;
    rem_o  = neg_rem_i ? (~urem_i + 1'b1) : urem_i;
    quo_o  = q;
    q_sext = {{EXT{q[HW-1]}}, q[HW-1:0]};
    ovf_u  = |q[W-1:HW];
    ovf_s  = (q != q_sext);
    flags_o.c = 1'b0;
    flags_o.v = word_i & (sgn_i ? ovf_s : ovf_u);
    flags_o.z = (q == '0);
    flags_o.n = (q != '0) & q[W-1];
  end
endmodule

// File: rtl/div_flags_unit.sv
module div_flags_unit
  import divf_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        dividend,
  input  logic [W-1:0]        divisor,
  input  logic                is_signed,
  input  logic                word_mode,
  output logic                out_valid,
  output logic [W-1:0]        quotient,
  output logic [W-1:0]        remainder,
  output logic [FLAG_W-1:0]   flags,
  output logic                div_zero
);
  localparam int ITER = W;
  localparam int CW   = $clog2(ITER);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  div_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic         neg_quo_q, neg_rem_q, sgn_q, word_q;

  logic [W-1:0] num_mag, den_mag;
  logic         neg_quo_c, neg_rem_c;
  logic         accept, den_zero, load;
  logic [W-1:0] core_quo, core_rem;
  logic [W-1:0] fx_quo, fx_rem;
  div_flags_t   fx_flags;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign den_zero = (divisor == '0);
  assign load     = accept & ~den_zero;

  div_operand_prep #(.W(W)) u_prep (
    .num_i     (dividend),
    .den_i     (divisor),
    .sgn_i     (is_signed),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag),
    .neg_quo_o (neg_quo_c),
    .neg_rem_o (neg_rem_c)
  );

  div_restoring_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (state_q == ST_RUN),
    .num_i  (num_mag),
    .den_i  (den_mag),
    .quo_o  (core_quo),
    .rem_o  (core_rem)
  );

  div_result_fix #(.W(W), .HW(HW)) u_fix (
    .uquo_i    (core_quo),
    .urem_i    (core_rem),
    .neg_quo_i (neg_quo_q),
    .neg_rem_i (neg_rem_q),
    .sgn_i     (sgn_q),
    .word_i    (word_q),
    .quo_o     (fx_quo),
    .rem_o     (fx_rem),
    .flags_o   (fx_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      sgn_q     <= 1'b0;
      word_q    <= 1'b0;
      out_valid <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      flags     <= '0;
    end else begin
      out_valid <= 1'b0;
      div_zero  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (den_zero) begin
              div_zero <= 1'b1;
            end else begin
              state_q   <= ST_RUN;
              cnt_q     <= '0;
              neg_quo_q <= neg_quo_c;
              neg_rem_q <= neg_rem_c;
              sgn_q     <= is_signed;
              word_q    <= word_mode;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          quotient  <= fx_quo;
          remainder <= fx_rem;
          flags     <= fx_flags;
          out_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_BLOCKED_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !div_zero); // R1
  AST_EXC_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> ($stable(quotient) && $stable(remainder) && $stable(flags) && !out_valid)); // R6
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flags[0]); // R7
  AST_ZN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(flags[3] && flags[2])); // R7
  AST_LONG_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !word_q) |-> !flags[1]); // R10
  AST_WORD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && word_q && !sgn_q && !flags[1]) |-> (quotient[W-1:HW] == '0)); // R8
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(quotient) && $stable(remainder) && $stable(flags))); // R11
endmodule

// File: tb/tb_div_flags_unit.sv
module tb_div_flags_unit;
  localparam int W   = 32;
  localparam int LAT = W + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] dividend, divisor;
  logic         is_signed, word_mode;
  logic         out_valid;
  logic [W-1:0] quotient, remainder;
  logic [3:0]   flags;
  logic         div_zero;

  div_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed),
    .word_mode(word_mode), .out_valid(out_valid), .quotient(quotient),
    .remainder(remainder), .flags(flags), .div_zero(div_zero)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  // reference model state
  bit           m_busy;
  int           m_cnt;
  bit           m_ov, m_dz;
  logic [W-1:0] m_q, m_r, p_q, p_r;
  logic [3:0]   m_f, p_f;
  string        t_res, t_flg, p_qt, p_ft, cur_qt, cur_ft;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit sgn, input bit wd,
                                  output logic [W-1:0] q, output logic [W-1:0] r,
                                  output logic [3:0] f);
    longint sa, sb, lq, lr;
    bit z, n, v;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      lq = sa / sb;
      lr = sa % sb;
      q = lq[W-1:0];
      r = lr[W-1:0];
    end else begin
      q = a / b;
      r = a % b;
    end
    z = (q == 0);
    n = !z && q[W-1];
    if (!wd) v = 0;
    else if (sgn) v = (q != {{16{q[15]}}, q[15:0]});
    else v = (q > 32'h0000_FFFF);
    f = {n, z, v, 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_ov = 0; m_dz = 0;
      m_q = '0; m_r = '0; m_f = '0;
      t_res = "R12"; t_flg = "R12";
    end else begin
      m_ov = 0; m_dz = 0; t_res = "R11"; t_flg = "R11";
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 0; m_ov = 1;
          m_q = p_q; m_r = p_r; m_f = p_f;
          t_res = p_qt; t_flg = p_ft;
        end
      end else if (in_valid) begin
        if (divisor == 0) begin
          m_dz = 1; t_res = "R6"; t_flg = "R6";
        end else begin
          m_busy = 1; m_cnt = 0;
          ref_div(dividend, divisor, is_signed, word_mode, p_q, p_r, p_f);
          p_qt = cur_qt; p_ft = cur_ft;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      chk(rst_n ? "R1" : "R12", "in_ready", W'(in_ready), W'(!m_busy));
      chk(rst_n ? "R2" : "R12", "out_valid", W'(out_valid), W'(m_ov));
      chk(rst_n ? "R6" : "R12", "div_zero", W'(div_zero), W'(m_dz));
      chk(t_res, "quotient", quotient, m_q);
      chk(t_res, "remainder", remainder, m_r);
      chk(t_flg, "flags", W'(flags), W'(m_f));
    end
  end

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn,
                    input bit wd, input string qt, input string ft);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_qt = qt; cur_ft = ft;
    dividend = a; divisor = b; is_signed = sgn; word_mode = wd; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; dividend = '0; divisor = '0;
    is_signed = 0; word_mode = 0; cur_qt = "R3"; cur_ft = "R7";
    repeat (3) @(negedge clk);
    rst_n = 1;

    op(32'd100, 32'd7, 0, 0, "R3", "R7");
    op(32'd0, 32'd5, 0, 0, "R3", "R7");
    op(32'hFFFF_FFFF, 32'd1, 0, 0, "R3", "R10");
    op(32'd5, 32'd9, 0, 0, "R3", "R7");
    op(-32'sd100, 32'd7, 1, 0, "R4", "R7");
    op(32'd100, -32'sd7, 1, 0, "R4", "R7");
    op(-32'sd100, -32'sd7, 1, 0, "R4", "R7");
    op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, "R5", "R5");
    op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, "R5", "R9");
    op(32'h0002_0000, 32'd1, 0, 1, "R8", "R8");
    op(32'h0000_FFFF, 32'd1, 0, 1, "R8", "R8");
    op(32'h1234_5678, 32'h10, 0, 1, "R8", "R8");
    op(32'h0000_8000, 32'd1, 1, 1, "R9", "R9");
    op(-32'sd32768, 32'd1, 1, 1, "R9", "R9");
    op(-32'sd32769, 32'd1, 1, 1, "R9", "R9");
    op(32'h0000_7FFF, 32'd1, 1, 1, "R9", "R9");
    wait_idle();

    // zero divisor: exception strobe, results frozen
    op(32'd123, 32'd0, 0, 0, "R6", "R6");
    op(32'd55, 32'd0, 1, 1, "R6", "R6");
    wait_idle();

    // requests offered while busy must be ignored
    op(32'd1000, 32'd10, 0, 0, "R3", "R7");
    dividend = 32'd7; divisor = 32'd0; in_valid = 1;
    repeat (6) @(negedge clk);
    in_valid = 0;
    wait_idle();

    // mixed operands, back to back
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? W'($urandom % 300 + 1) : $urandom;
      if (b == 0) b = 1;
      op(a, b, i[0], i[1], i[0] ? "R4" : "R3", "R7");
    end
    wait_idle();
    finish_run();
  end
endmodule